// File: doc/BRIEF.md
# Streaming 3x3 Blur with Gain

This block filters a raster stream of 8-bit grayscale pixels, one pixel per accepted transfer. Each output pixel is a 3x3 binomial smoothing of its neighbourhood, then scaled by an 8-bit gain in Q4 fixed point and saturated back to 8 bits. The output frame has the same width and height as the input frame. Image borders are padded by replicating the nearest edge pixel or line. Two line memories hold the previous rows, sized for a maximum width. The active width, the frame height and the gain are taken from plain configuration pins and sampled when the first pixel of a frame is accepted.

Both the input and the output use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. The whole filter advances only when its single output register is free, which means it is empty or being read on that edge. When the consumer holds `m_ready` low, `s_ready` drops in the same cycle and nothing inside the block moves. Output rows lag input rows by one line. After the last pixel of each line the block adds one internal cycle to emit the right-edge pixel. After the last line it keeps `s_ready` low while it emits the final row from its line memories. The end of a frame is therefore known from the height count, not from the start of the next frame.

Top module: `blur3g_stream`

## Requirements
- R1: Each output pixel is the sum over the 3x3 neighbourhood weighted 1,2,1 / 2,4,2 / 1,2,1, shifted right by 4 with truncation. The sum is formed at a width where it cannot wrap.
- R2: The smoothed value is multiplied by the frame's gain and shifted right by 4 with truncation. A gain of 16 passes the value unchanged and a gain of 0 gives 0.
- R3: Any scaled result above 255 is output as 255.
- R4: Neighbours outside the frame take the value of the nearest pixel in the frame, in both directions. This holds for frames one pixel wide or one line high.
- R5: Every frame produces exactly width x height output pixels in raster order. The last row is emitted after the last input pixel without further input, and `s_ready` is low in the cycle after that last input pixel is accepted.
- R6: While it waits for a frame, the block accepts and discards pixels with `s_sof` low. A pixel with `s_sof` high starts the frame as its top-left pixel. `m_sof` is high on the first output pixel of a frame and on no other.
- R7: `m_eol` is high on the last output pixel of every row and on no other.
- R8: `cfg_width`, `cfg_height` and `cfg_gain` are sampled when the start-of-frame pixel is accepted. Changing them later in the frame has no effect on that frame.
- R9: After reset `m_valid` is low. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data`, `m_sof` and `m_eol` hold their values. No pixel is lost or repeated under back-pressure on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Block can take an input pixel |
| s_data | input | 8 | Input pixel value |
| s_sof | input | 1 | Input pixel is the first of a frame |
| s_eol | input | 1 | Input pixel is the last of a line |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Consumer takes the output pixel |
| m_data | output | 8 | Filtered, scaled, saturated pixel |
| m_sof | output | 1 | Output pixel is the first of a frame |
| m_eol | output | 1 | Output pixel is the last of a row |
| cfg_width | input | 7 | Active width, 1 to MAX_W |
| cfg_height | input | 11 | Frame height in lines, at least 1 |
| cfg_gain | input | 8 | Gain in Q4, 16 is unity |

## Verification
The assertions rely on three things about the inputs. Once a frame has started, `s_eol` arrives exactly on the pixel that completes the sampled active width. `cfg_width` lies between 1 and MAX_W. `cfg_height` is at least 1. The stimulus builds every line from the same width value it loads into `cfg_width`, and raises `s_eol` only on the last column. It keeps configurations legal, and it sends its deliberately unframed pixels only while the block is still waiting for a frame, where alignment is not required. Input gaps and consumer stalls follow fixed cycle patterns, so back-pressure hits both handshakes at many different points in a line.

// File: rtl/blur3g_pkg.sv
package blur3g_pkg;

  // Sum of kernel weights is 16, so the normalising shift is 4.
  localparam int KERNEL_SHIFT = 4;
  // Gain is unsigned Q4: 16 means 1.0.
  localparam int GAIN_FRAC = 4;

  typedef enum logic [2:0] {
    ST_SOF,   // waiting for a start-of-frame pixel
    ST_ROW,   // consuming input pixels of a line
    ST_EXT,   // extra step: right-edge output of a line
    ST_BOT,   // bottom flush: last row from line memories
    ST_BEXT   // right-edge output of the bottom flush row
  } blur_state_e;

endpackage

// File: rtl/blur3g_ctrl.sv
module blur3g_ctrl
  import blur3g_pkg::*;
#(
  parameter int MAX_W  = 64,
  parameter int MAX_H  = 1024,
  parameter int GAIN_W = 8,
  localparam int CW = $clog2(MAX_W),
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic              s_sof,
  input  logic              s_eol,
  input  logic [WW-1:0]     cfg_width,
  input  logic [HW-1:0]     cfg_height,
  input  logic [GAIN_W-1:0] cfg_gain,
  input  logic              slot_free,
  output logic              s_ready,
  output logic              step,
  output logic              lb_we,
  output logic [CW-1:0]     col,
  output logic              top_dup,
  output logic              flush,
  output logic              first,
  output logic              ext,
  output logic              emit,
  output logic              o_sof,
  output logic              o_eol,
  output logic [GAIN_W-1:0] gain_q
);

  blur_state_e   state;
  logic [CW-1:0] col_q;
  logic [HW-1:0] row_q, hgt_q, row_cur, hgt;
  logic [WW-1:0] wid_q, wid;
  logic          take, sof_take, last_col, last_row, in_phase;

  assign in_phase = (state == ST_SOF) || (state == ST_ROW);
  assign s_ready  = in_phase && slot_free;
  assign take     = s_valid && s_ready;
  assign sof_take = (state == ST_SOF) && take && s_sof;

  // Before the frame is latched, the live configuration is in force.
  assign wid      = (state == ST_SOF) ? cfg_width  : wid_q;
  assign hgt      = (state == ST_SOF) ? cfg_height : hgt_q;
  assign row_cur  = (state == ST_SOF) ? '0 : row_q;
  assign last_col = (WW'(col_q) == wid - WW'(1));
  assign last_row = (row_cur == hgt - HW'(1));

  always_comb begin
    case (state)
      ST_SOF:  step = sof_take;
      ST_ROW:  step = take;
      default: step = slot_free;
    endcase
  end

  assign col     = col_q;
  assign ext     = (state == ST_EXT) || (state == ST_BEXT);
  assign flush   = (state == ST_BOT);
  assign first   = (col_q == '0) && !ext;
  assign lb_we   = step && in_phase;
  assign top_dup = flush ? (hgt_q < HW'(2)) : (row_cur < HW'(2));
  assign o_eol   = ext;

  always_comb begin
    emit  = 1'b0;
    o_sof = 1'b0;
    case (state)
      ST_ROW: begin
        emit  = (row_q != '0) && (col_q != '0);
        o_sof = (row_q == HW'(1)) && (col_q == CW'(1));
      end
      ST_EXT: begin
        emit  = 1'b1;
        o_sof = (row_q == HW'(1)) && (wid_q == WW'(1));
      end
      ST_BOT: begin
        emit  = (col_q != '0);
        o_sof = (hgt_q == HW'(1)) && (col_q == CW'(1));
      end
      ST_BEXT: begin
        emit  = 1'b1;
        o_sof = (hgt_q == HW'(1)) && (wid_q == WW'(1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_SOF;
      col_q  <= '0;
      row_q  <= '0;
      wid_q  <= WW'(1);
      hgt_q  <= HW'(1);
      gain_q <= GAIN_W'(16);
    end else begin
      if (sof_take) begin
        wid_q  <= cfg_width;
        hgt_q  <= cfg_height;
        gain_q <= cfg_gain;
      end
      if (step) begin
        case (state)
          ST_SOF, ST_ROW: begin
            if (!last_col) begin
              col_q <= col_q + CW'(1);
              row_q <= row_cur;
              state <= ST_ROW;
            end else begin
              col_q <= '0;
              if (row_cur != '0) begin
                row_q <= row_cur;
                state <= ST_EXT;
              end else if (last_row) begin
                row_q <= row_cur;
                state <= ST_BOT;
              end else begin
                row_q <= HW'(1);
                state <= ST_ROW;
              end
            end
          end
          ST_EXT: begin
            if (row_q == hgt_q - HW'(1)) begin
              state <= ST_BOT;
            end else begin
              row_q <= row_q + HW'(1);
              state <= ST_ROW;
            end
          end
          ST_BOT: begin
            if (last_col) begin
              col_q <= '0;
              state <= ST_BEXT;
            end else begin
              col_q <= col_q + CW'(1);
            end
          end
          ST_BEXT: state <= ST_SOF;
          default: state <= ST_SOF;
        endcase
      end
    end
  end

  // Input rule: inside a frame, end-of-line comes exactly at the sampled width.
  assert_eol_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (state == ST_ROW || sof_take)) |-> (s_eol == last_col));

  // Last input pixel of a frame closes the input until the flush is done.
  assert_flush_closes_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_we && last_col && last_row) |=> !s_ready);

  assert_col_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SOF) |-> (WW'(col_q) < wid_q));

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SOF) |=> ($stable(gain_q) && $stable(wid_q) && $stable(hgt_q)));

endmodule

// File: rtl/blur3g_linebuf.sv
module blur3g_linebuf #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int NL    = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [NL-1:0][DW-1:0]  taps
);

  // mem[0] holds the newest stored line, mem[NL-1] the oldest.
  logic [DW-1:0] mem [NL][DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[0][addr] <= wdata;
      for (int k = 1; k < NL; k++) begin
        mem[k][addr] <= mem[k-1][addr];
      end
    end
  end

  for (genvar k = 0; k < NL; k++) begin : g_tap
    assign taps[k] = mem[k][addr];
  end

endmodule

// File: rtl/blur3g_hfilt.sv
module blur3g_hfilt #(
  parameter int DW = 8,
  localparam int VW = DW + 2,
  localparam int SW = DW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          first,
  input  logic          ext,
  input  logic [DW-1:0] top,
  input  logic [DW-1:0] mid,
  input  logic [DW-1:0] bot,
  output logic [SW-1:0] sum
);

  logic [VW-1:0] v, v1, v2, vr;

  // Vertical 1-2-1 on the incoming column, widened so it cannot wrap.
  assign v  = VW'(top) + (VW'(mid) << 1) + VW'(bot);
  // On the extra step the right neighbour repeats the last column.
  assign vr = ext ? v1 : v;
  assign sum = SW'(v2) + (SW'(v1) << 1) + SW'(vr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= '0;
      v2 <= '0;
    end else if (step && !ext) begin
      if (first) begin
        v1 <= v;     // left neighbour of column 0 repeats column 0
        v2 <= v;
      end else begin
        v1 <= v;
        v2 <= v1;
      end
    end
  end

endmodule

// File: rtl/blur3g_scale.sv
module blur3g_scale
  import blur3g_pkg::*;
#(
  parameter int DW     = 8,
  parameter int GAIN_W = 8,
  localparam int SW = DW + 4,
  localparam int PW = DW + GAIN_W,
  localparam int QW = PW - GAIN_FRAC
) (
  input  logic [SW-1:0]     sum,
  input  logic [GAIN_W-1:0] gain,
  output logic [DW-1:0]     pix
);

  logic [DW-1:0] blur;
  logic [PW-1:0] prod;
  logic [QW-1:0] scaled;

  assign blur   = sum[SW-1:KERNEL_SHIFT];
  assign prod   = PW'(blur) * PW'(gain);
  assign scaled = prod[PW-1:GAIN_FRAC];
  assign pix    = (scaled > QW'({DW{1'b1}})) ? {DW{1'b1}} : scaled[DW-1:0];

endmodule

// File: rtl/blur3g_stream.sv
module blur3g_stream #(
  parameter int MAX_W  = 64,
  parameter int MAX_H  = 1024,
  parameter int DW     = 8,
  parameter int GAIN_W = 8,
  localparam int CW = $clog2(MAX_W),
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1),
  localparam int SW = DW + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DW-1:0]     s_data,
  input  logic              s_sof,
  input  logic              s_eol,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DW-1:0]     m_data,
  output logic              m_sof,
  output logic              m_eol,
  input  logic [WW-1:0]     cfg_width,
  input  logic [HW-1:0]     cfg_height,
  input  logic [GAIN_W-1:0] cfg_gain
);

  logic                 slot_free, step, lb_we, top_dup, flush, first, ext, emit;
  logic                 o_sof, o_eol;
  logic [CW-1:0]        col;
  logic [GAIN_W-1:0]    gain_q;
  logic [1:0][DW-1:0]   taps;
  logic [DW-1:0]        top, mid, bot, pix;
  logic [SW-1:0]        sum;

  assign slot_free = !m_valid || m_ready;

  blur3g_ctrl #(.MAX_W(MAX_W), .MAX_H(MAX_H), .GAIN_W(GAIN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_sof(s_sof), .s_eol(s_eol),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_gain(cfg_gain),
    .slot_free(slot_free), .s_ready(s_ready), .step(step), .lb_we(lb_we),
    .col(col), .top_dup(top_dup), .flush(flush), .first(first), .ext(ext),
    .emit(emit), .o_sof(o_sof), .o_eol(o_eol), .gain_q(gain_q)
  );

  blur3g_linebuf #(.DEPTH(MAX_W), .DW(DW), .NL(2)) u_lines (
    .clk(clk), .we(lb_we), .addr(col), .wdata(s_data), .taps(taps)
  );

  // taps[0] = line above the current one, taps[1] = two lines above.
  assign mid = taps[0];
  assign top = top_dup ? taps[0] : taps[1];
  assign bot = flush ? taps[0] : s_data;

  blur3g_hfilt #(.DW(DW)) u_hfilt (
    .clk(clk), .rst_n(rst_n), .step(step), .first(first), .ext(ext),
    .top(top), .mid(mid), .bot(bot), .sum(sum)
  );

  blur3g_scale #(.DW(DW), .GAIN_W(GAIN_W)) u_scale (
    .sum(sum), .gain(gain_q), .pix(pix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_sof   <= 1'b0;
      m_eol   <= 1'b0;
    end else if (slot_free) begin
      m_valid <= step && emit;
      if (step && emit) begin
        m_data <= pix;
        m_sof  <= o_sof;
        m_eol  <= o_eol;
      end
    end
  end

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sof) && $stable(m_eol)));

  assert_no_input_when_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

endmodule

// File: tb/test_blur3g_stream.sv
`timescale 1ns/1ps
module test_blur3g_stream;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_sof = 1'b0, s_eol = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready;
  logic        m_valid, m_sof, m_eol;
  logic        m_ready = 1'b1;
  logic [7:0]  m_data;
  logic [6:0]  cfg_width = 7'd1;
  logic [10:0] cfg_height = 11'd1;
  logic [7:0]  cfg_gain = 8'd16;

  int checks = 0, errors = 0, cyc = 0, cnt = 0, stall_mode = 0;
  int got_pix [0:511];
  bit got_sof [0:511];
  bit got_eol [0:511];
  bit prev_hold = 0;
  int prev_data = 0;
  bit prev_sof = 0, prev_eol = 0;

  always #5 clk = ~clk;

  blur3g_stream i_blur3g_stream (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_eol(s_eol), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sof(m_sof), .m_eol(m_eol), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_gain(cfg_gain)
  );

  // width, height, gain, gain after first pixel, image seed, stall mode
  localparam int NF = 7;
  localparam int TBL [NF][6] = '{
    '{ 8, 6,  16,  16,  3, 0},
    '{ 1, 5,  24,  99,  5, 1},
    '{ 7, 1,  40,  40,  9, 2},
    '{ 1, 1, 255,   0,  0, 0},
    '{16, 4,   0,  77, 11, 3},
    '{ 5, 3,   8,   8,  0, 1},
    '{64, 2,  20, 200,  7, 2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int px(input int seed, input int x, input int y);
    if (seed == 0) return 200;
    return (seed * 37 + x * 13 + y * y * 7 + x * y * 5) & 255;
  endfunction

  function automatic int clampi(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int model(input int seed, input int x, input int y,
                               input int w, input int h, input int g);
    int s = 0;
    for (int dy = -1; dy <= 1; dy++) begin
      for (int dx = -1; dx <= 1; dx++) begin
        int wy = (dy == 0) ? 2 : 1;
        int wx = (dx == 0) ? 2 : 1;
        s += wy * wx * px(seed, clampi(x + dx, w - 1), clampi(y + dy, h - 1));
      end
    end
    s = s / 16;
    s = (s * g) / 16;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic bit in_gap();
    return (stall_mode == 1 && (cyc % 3) == 0) || (stall_mode == 3 && ((cyc * 7) % 5) == 0);
  endfunction

  function automatic bit out_hold();
    return (stall_mode == 2 && (cyc % 2) == 1) || (stall_mode == 3 && ((cyc * 3) % 7) < 2);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Output side: drive ready, check hold under stall, capture transfers.
  always @(negedge clk) begin
    m_ready = !out_hold();
    #1;
    if (rst_n && prev_hold) begin
      chk(m_valid && m_data == prev_data && m_sof == prev_sof && m_eol == prev_eol,
          "R9 output held while stalled", int'(m_data), prev_data);
    end
    prev_hold = rst_n && m_valid && !m_ready;
    prev_data = int'(m_data);
    prev_sof  = m_sof;
    prev_eol  = m_eol;
    if (rst_n && m_valid && m_ready && cnt < 512) begin
      got_pix[cnt] = int'(m_data);
      got_sof[cnt] = m_sof;
      got_eol[cnt] = m_eol;
      cnt++;
    end
  end

  task automatic run_frame(input int w, input int h, input int g, input int g2,
                           input int seed, input int mode, input int junk);
    int n = w * h;
    int idx = 0;
    int jd = 0;
    int t = 0;
    stall_mode = mode;
    cfg_width = 7'(w);
    cfg_height = 11'(h);
    cfg_gain = 8'(g);
    cnt = 0;
    // Unframed pixels before the frame must be swallowed (R6).
    while (jd < junk) begin
      @(negedge clk);
      s_valid = 1'b1; s_sof = 1'b0; s_eol = 1'b0; s_data = 8'hAA;
      #1;
      if (s_ready) jd++;
    end
    while (idx < n) begin
      @(negedge clk);
      if (idx == 1) begin
        // Mid-frame changes must not affect this frame (R8).
        cfg_gain = 8'(g2);
        cfg_width = 7'd3;
        cfg_height = 11'd2;
      end
      if (in_gap()) begin
        s_valid = 1'b0;
      end else begin
        s_valid = 1'b1;
        s_data  = 8'(px(seed, idx % w, idx / w));
        s_sof   = (idx == 0);
        s_eol   = ((idx % w) == w - 1);
      end
      #1;
      if (s_valid && s_ready) idx++;
    end
    @(negedge clk);
    s_valid = 1'b0;
    #1;
    chk(!s_ready, "R5 input closed after last pixel", int'(s_ready), 0);
    while (cnt < n && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (10) @(negedge clk);
    chk(cnt == n, "R5 output pixel count", cnt, n);
    for (int k = 0; k < n && k < cnt; k++) begin
      int x = k % w;
      int y = k / w;
      int e = model(seed, x, y, w, h, g);
      chk(got_pix[k] == e, "R1/R2/R3/R4/R8 pixel value", got_pix[k], e);
      chk(got_sof[k] == (k == 0), "R6 output sof flag", int'(got_sof[k]), int'(k == 0));
      chk(got_eol[k] == (x == w - 1), "R7 output eol flag", int'(got_eol[k]), int'(x == w - 1));
    end
    stall_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(m_valid == 1'b0, "R9 m_valid low in reset", int'(m_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(m_valid == 1'b0, "R9 m_valid low after reset", int'(m_valid), 0);
    chk(s_ready == 1'b1, "R6 ready for a frame after reset", int'(s_ready), 1);

    for (int f = 0; f < NF; f++) begin
      run_frame(TBL[f][0], TBL[f][1], TBL[f][2], TBL[f][3], TBL[f][4], TBL[f][5], 0);
    end

    // R6: unframed pixels dropped, then a normal frame.
    run_frame(4, 3, 32, 32, 13, 0, 3);
    // R3: constant bright image, gain saturates everything.
    run_frame(6, 2, 255, 16, 0, 3, 0);
    // R4: single-column tall frame with both stalls.
    run_frame(1, 8, 16, 16, 21, 3, 2);
    // R2: back-to-back frame with unity gain to confirm nothing carried over.
    run_frame(3, 3, 16, 16, 17, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule